// File: doc/BRIEF.md
# Debug POST-Code Capture Queue

This block watches host I/O write strokes aimed at the two debug-code byte addresses (80h and 81h by default). Every byte that lands on one of those addresses is put into a 16-entry queue along with the current value of a free-running 24-bit time counter. Firmware learns that codes are waiting from a status word. It then pulls them out one at a time by reading a capture word, which yields the code in the low byte and its time of arrival above it.

The host side is a single-cycle write strobe that carries a byte address, two byte enables and 16 data bits. Lane 0 targets the given address and lane 1 targets the next one. A mode input selects how a 16-bit stroke is handled. In split mode both lanes are captured, and the lower address comes first. In unsplit mode only the low lane is kept.

A fill level above a programmable threshold latches an interrupt-pending bit. Software can clear that bit by writing 1 to it, but it sets again while the fill stays high. The pending bit drives the interrupt line only when an enable bit is set.

Top module: `postcode_capture`

## Requirements
- R1: Only bytes whose target address is 80h or 81h are captured. Lane 0 targets `host_addr` and lane 1 targets `host_addr`+1. Any other target leaves the queue unchanged.
- R2: A capture word holds the code in bits [7:0] and, in bits [31:8], the time counter value at the clock edge that accepted the write.
- R3: With `wide_nosplit`=0, a write whose two enabled lanes both hit queues two entries, lane 0 first. Successive byte writes queue in arrival order.
- R4: With `wide_nosplit`=1, lane 1 is never captured, so a 16-bit write at 80h queues one entry holding data bits [7:0].
- R5: Register select 0 (status) reads bit 0 = queue not empty and bits [12:8] = fill count.
- R6: A read of register select 1 (capture) returns the head entry and removes it. When the queue is empty, it returns 0 and changes nothing.
- R7: The queue holds 16 entries. A byte arriving when there is no room is dropped and sets sticky status bit 1. Writing 1 to that bit clears it, but a drop in the same cycle wins.
- R8: The time counter advances by one on each cycle with `stamp_tick` high and wraps to zero after its maximum value.
- R9: Register select 3 bit 0 (pending) sets on the edge after the fill exceeds the threshold. The threshold is register select 2, bits [4:0], and a fill equal to it does not set the bit. Writing 1 clears pending for one cycle, after which it sets again if the fill is still above the threshold.
- R10: `irq` is high only while pending is set and enable bit 8 of register select 2 is 1.
- R11: A capture read and an arriving byte in the same cycle on a full queue both take effect. The head is returned, the new byte is stored, and the fill stays 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stamp_tick | input | 1 | Time counter advance enable |
| host_wr | input | 1 | Host I/O write strobe, one cycle per write |
| host_addr | input | 16 | Byte address of lane 0 |
| host_be | input | 2 | Byte enables, bit n for lane n |
| host_data | input | 16 | Write data, lane n in bits [8n+7:8n] |
| wide_nosplit | input | 1 | 1: keep only lane 0 of each write |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on capture) |
| reg_addr | input | 2 | Register select: 0 status, 1 capture, 2 control, 3 pending |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of `reg_rd`, zero otherwise |
| irq | output | 1 | Interrupt request |

## Verification
A firmware capture read and a host byte arrival can fall in the same clock cycle, and this matters most when the queue is full, because the pop must free room for the push. The bench fills the queue to 16 entries and then asserts the capture read together with a byte write in one cycle. It expects the old head in the read data, a fill still at 16, no new overrun, and the new byte as the last entry of the full drain. The overrun set and its write-1 clear meeting in one cycle are likewise ordered so that the drop wins.

// File: rtl/pcap_pkg.sv
package pcap_pkg;

    localparam int CODE_W = 8;

    localparam int ST_NOTEMPTY = 0;
    localparam int ST_OVERRUN  = 1;
    localparam int ST_FILL_LSB = 8;
    localparam int CTL_EN_BIT  = 8;

    typedef enum logic [1:0] {
        SEL_STATUS  = 2'd0,
        SEL_CAPTURE = 2'd1,
        SEL_CONTROL = 2'd2,
        SEL_INTSRC  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              vld;
        logic [CODE_W-1:0] code;
    } code_slot_t;

endpackage

// File: rtl/pcap_lane_decode.sv
module pcap_lane_decode
    import pcap_pkg::*;
#(
    parameter int            AW   = 16,
    parameter logic [AW-1:0] BASE = 'h80
) (
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [1:0]    be,
    input  logic [15:0]   data,
    input  logic          nosplit,
    output code_slot_t    slot0,
    output code_slot_t    slot1
);

    localparam int LANES = 2;

    logic [LANES-1:0]             hit;
    logic [LANES-1:0][CODE_W-1:0] lane_code;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [AW-1:0] tgt;
        logic          addr_ok;
        assign tgt          = addr + AW'(g);
        assign addr_ok      = (tgt == BASE) || (tgt == BASE + AW'(1));
        assign lane_code[g] = data[CODE_W*g +: CODE_W];
        if (g == 0) begin : g_low
            assign hit[g] = wr & be[g] & addr_ok;
        end else begin : g_high
            assign hit[g] = wr & be[g] & addr_ok & ~nosplit;
        end
    end

    // Compact hits so that slot0 always carries the first captured byte.
    always_comb begin
        slot0.vld  = |hit;
        slot0.code = hit[0] ? lane_code[0] : lane_code[1];
        slot1.vld  = &hit;
        slot1.code = lane_code[1];
    end

endmodule

// File: rtl/pcap_stamp.sv
module pcap_stamp #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    output logic [W-1:0] stamp
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } stamp_st_t;

    stamp_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick) begin
            st_d.cnt = st_q.cnt + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stamp = st_q.cnt;

endmodule

// File: rtl/pcap_fifo.sv
module pcap_fifo #(
    parameter  int DEPTH = 16,
    parameter  int EW    = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in0_vld,
    input  logic [EW-1:0]    in0_data,
    input  logic             in1_vld,
    input  logic [EW-1:0]    in1_data,
    input  logic             pop_req,
    output logic [EW-1:0]    head,
    output logic [CNT_W-1:0] count,
    output logic             dropped
);

    typedef struct packed {
        logic [DEPTH-1:0][EW-1:0] mem;
        logic [PTR_W-1:0]         wptr;
        logic [PTR_W-1:0]         rptr;
        logic [CNT_W-1:0]         cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    logic           do_pop;
    logic           acc0;
    logic           acc1;
    logic [CNT_W:0] room;

    always_comb begin
        do_pop  = pop_req && (st_q.cnt != '0);
        // A pop in the same cycle frees its slot for the incoming bytes.
        room    = (CNT_W+1)'(DEPTH) - {1'b0, st_q.cnt} + (CNT_W+1)'(do_pop);
        acc0    = in0_vld && (room >= (CNT_W+1)'(1));
        acc1    = in1_vld && (room >= (acc0 ? (CNT_W+1)'(2) : (CNT_W+1)'(1)));
        dropped = (in0_vld && !acc0) || (in1_vld && !acc1);

        st_d = st_q;
        if (acc0) begin
            st_d.mem[st_q.wptr] = in0_data;
        end
        if (acc1) begin
            st_d.mem[st_q.wptr + PTR_W'(acc0)] = in1_data;
        end
        st_d.wptr = st_q.wptr + PTR_W'(acc0) + PTR_W'(acc1);
        st_d.rptr = st_q.rptr + PTR_W'(do_pop);
        st_d.cnt  = st_q.cnt + CNT_W'(acc0) + CNT_W'(acc1) - CNT_W'(do_pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head  = st_q.mem[st_q.rptr];
    assign count = st_q.cnt;

endmodule

// File: rtl/postcode_capture.sv
module postcode_capture
    import pcap_pkg::*;
#(
    parameter  int            AW      = 16,
    parameter  logic [AW-1:0] BASE    = 16'h0080,
    parameter  int            DEPTH   = 16,
    parameter  int            STAMP_W = 24,
    localparam int            CNT_W   = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stamp_tick,
    input  logic          host_wr,
    input  logic [AW-1:0] host_addr,
    input  logic [1:0]    host_be,
    input  logic [15:0]   host_data,
    input  logic          wide_nosplit,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [1:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          irq
);

    localparam int EW = CODE_W + STAMP_W;

    typedef struct packed {
        logic [CNT_W-1:0] level;
        logic             irq_en;
        logic             pend;
        logic             ovr;
    } ctl_st_t;

    ctl_st_t ctl_d, ctl_q;

    code_slot_t       slot0;
    code_slot_t       slot1;
    logic [STAMP_W-1:0] stamp;
    logic [EW-1:0]    head;
    logic [CNT_W-1:0] fill_cnt;
    logic             dropped;
    logic             pop;
    reg_sel_e         sel;
    logic [31:0]      word;
    logic             over;
    logic             ovr_clr;
    logic             pend_clr;

    logic [CNT_W-1:0] level_q;
    logic             en_q;
    logic             pend_q;

    assign sel = reg_sel_e'(reg_addr);
    assign pop = reg_rd && (sel == SEL_CAPTURE);

    pcap_lane_decode #(
        .AW   (AW),
        .BASE (BASE)
    ) dec_i (
        .wr      (host_wr),
        .addr    (host_addr),
        .be      (host_be),
        .data    (host_data),
        .nosplit (wide_nosplit),
        .slot0   (slot0),
        .slot1   (slot1)
    );

    pcap_stamp #(
        .W (STAMP_W)
    ) stamp_i (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (stamp_tick),
        .stamp (stamp)
    );

    pcap_fifo #(
        .DEPTH (DEPTH),
        .EW    (EW)
    ) fifo_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in0_vld  (slot0.vld),
        .in0_data ({stamp, slot0.code}),
        .in1_vld  (slot1.vld),
        .in1_data ({stamp, slot1.code}),
        .pop_req  (pop),
        .head     (head),
        .count    (fill_cnt),
        .dropped  (dropped)
    );

    always_comb begin
        over     = fill_cnt > ctl_q.level;
        ovr_clr  = reg_wr && (sel == SEL_STATUS) && reg_wdata[ST_OVERRUN];
        pend_clr = reg_wr && (sel == SEL_INTSRC) && reg_wdata[0];

        ctl_d = ctl_q;
        if (reg_wr && (sel == SEL_CONTROL)) begin
            ctl_d.level  = reg_wdata[CNT_W-1:0];
            ctl_d.irq_en = reg_wdata[CTL_EN_BIT];
        end
        // Clear has priority for one cycle; the level condition sets it again.
        ctl_d.pend = pend_clr ? 1'b0 : (ctl_q.pend | over);
        // A drop outranks a simultaneous write-1 clear.
        ctl_d.ovr  = dropped ? 1'b1 : (ovr_clr ? 1'b0 : ctl_q.ovr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        word = '0;
        unique case (sel)
            SEL_STATUS: begin
                word[ST_NOTEMPTY]            = (fill_cnt != '0);
                word[ST_OVERRUN]             = ctl_q.ovr;
                word[ST_FILL_LSB +: CNT_W]   = fill_cnt;
            end
            SEL_CAPTURE: begin
                if (fill_cnt != '0) begin
                    word[EW-1:0] = head;
                end
            end
            SEL_CONTROL: begin
                word[CNT_W-1:0]  = ctl_q.level;
                word[CTL_EN_BIT] = ctl_q.irq_en;
            end
            SEL_INTSRC: begin
                word[0] = ctl_q.pend;
            end
            default: word = '0;
        endcase
        reg_rdata = reg_rd ? word : '0;
    end

    assign level_q = ctl_q.level;
    assign en_q    = ctl_q.irq_en;
    assign pend_q  = ctl_q.pend;
    assign irq     = pend_q & en_q;

endmodule

// File: rtl/pcap_checker.sv
module pcap_checker #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq,
    input logic             host_wr,
    input logic             reg_rd,
    input logic             reg_wr,
    input logic [1:0]       reg_addr,
    input logic [31:0]      reg_wdata,
    input logic [31:0]      reg_rdata,
    input logic [CNT_W-1:0] fill,
    input logic [CNT_W-1:0] level,
    input logic             en,
    input logic             pend
);

    p_fill_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fill) <= DEPTH);

    p_fill_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (int'(fill) <= int'($past(fill)) + 2));

    p_empty_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 2'd1 && fill == '0) |-> (reg_rdata == 32'd0));

    p_empty_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 2'd1 && fill == '0 && !host_wr) |=> (fill == '0));

    p_notempty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 2'd0) |-> (reg_rdata[0] == (fill != '0)));

    p_pend_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fill > level && !(reg_wr && reg_addr == 2'd3 && reg_wdata[0])) |=> pend);

    p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !irq);

endmodule

bind postcode_capture pcap_checker #(
    .DEPTH (DEPTH),
    .CNT_W (CNT_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq       (irq),
    .host_wr   (host_wr),
    .reg_rd    (reg_rd),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .fill      (fill_cnt),
    .level     (level_q),
    .en        (en_q),
    .pend      (pend_q)
);

// File: tb/postcode_capture_tb_top.sv
module postcode_capture_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] A_STATUS  = 2'd0;
    localparam logic [1:0] A_CAPTURE = 2'd1;
    localparam logic [1:0] A_CONTROL = 2'd2;
    localparam logic [1:0] A_INTSRC  = 2'd3;

    typedef struct packed {
        logic [15:0] addr;
        logic [1:0]  be;
        logic [15:0] data;
        logic        ns;
        logic [1:0]  n;
        logic [7:0]  b0;
        logic [7:0]  b1;
    } vec_t;

    localparam int NVEC = 9;
    // Covers R1 (address window), R3 (split order), R4 (unsplit mode).
    localparam vec_t VECS [NVEC] = '{
        '{16'h0080, 2'b01, 16'h00A5, 1'b0, 2'd1, 8'hA5, 8'h00},
        '{16'h0080, 2'b11, 16'h1234, 1'b0, 2'd2, 8'h34, 8'h12},
        '{16'h0080, 2'b11, 16'hBEEF, 1'b1, 2'd1, 8'hEF, 8'h00},
        '{16'h0081, 2'b01, 16'h0077, 1'b0, 2'd1, 8'h77, 8'h00},
        '{16'h0090, 2'b01, 16'h0055, 1'b0, 2'd0, 8'h00, 8'h00},
        '{16'h007F, 2'b11, 16'h6600, 1'b0, 2'd1, 8'h66, 8'h00},
        '{16'h0081, 2'b11, 16'h2211, 1'b0, 2'd1, 8'h11, 8'h00},
        '{16'h0080, 2'b10, 16'hC300, 1'b0, 2'd1, 8'hC3, 8'h00},
        '{16'h0080, 2'b10, 16'hC300, 1'b1, 2'd0, 8'h00, 8'h00}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stamp_tick = 1'b0;
    logic        host_wr = 1'b0;
    logic [15:0] host_addr = '0;
    logic [1:0]  host_be = '0;
    logic [15:0] host_data = '0;
    logic        wide_nosplit = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic [31:0] rdata_w;
    logic        irq_w;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] v;
    logic [31:0] vw;

    always #(CLK_PERIOD/2) clk = ~clk;

    postcode_capture dut_i (
        .clk (clk), .rst_n (rst_n), .stamp_tick (stamp_tick),
        .host_wr (host_wr), .host_addr (host_addr), .host_be (host_be),
        .host_data (host_data), .wide_nosplit (wide_nosplit),
        .reg_wr (reg_wr), .reg_rd (reg_rd), .reg_addr (reg_addr),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .irq (irq)
    );

    // Narrow time counter copy, used only to reach the wrap point quickly.
    postcode_capture #(.STAMP_W (4)) dut_w (
        .clk (clk), .rst_n (rst_n), .stamp_tick (stamp_tick),
        .host_wr (host_wr), .host_addr (host_addr), .host_be (host_be),
        .host_data (host_data), .wide_nosplit (wide_nosplit),
        .reg_wr (reg_wr), .reg_rd (reg_rd), .reg_addr (reg_addr),
        .reg_wdata (reg_wdata), .reg_rdata (rdata_w), .irq (irq_w)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic host_write(input logic [15:0] a, input logic [1:0] be,
                              input logic [15:0] d, input logic ns);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_be = be; host_data = d; wide_nosplit = ns;
        @(negedge clk);
        host_wr = 1'b0; wide_nosplit = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] val, output logic [31:0] valw);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1;
        val  = reg_rdata;
        valw = rdata_w;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        stamp_tick = 1'b1;
        repeat (n) @(negedge clk);
        stamp_tick = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        do_reset();

        // Reset state (R5, R9, R10)
        reg_read(A_STATUS, v, vw);  check("R5 reset status", v, 32'h0);
        reg_read(A_CONTROL, v, vw); check("R10 reset control", v, 32'h0);
        reg_read(A_INTSRC, v, vw);  check("R9 reset pending", v, 32'h0);
        check("R10 reset irq", {31'b0, irq}, 32'h0);
        // R6: empty capture read returns zero and leaves fill at zero
        reg_read(A_CAPTURE, v, vw); check("R6 empty read", v, 32'h0);
        reg_read(A_STATUS, v, vw);  check("R6 empty read no change", v, 32'h0);

        // Vector table: R1 R2 R3 R4 R5
        for (int i = 0; i < NVEC; i++) begin
            host_write(VECS[i].addr, VECS[i].be, VECS[i].data, VECS[i].ns);
            reg_read(A_STATUS, v, vw);
            check("R1 R3 R4 fill", {27'b0, v[12:8]}, {30'b0, VECS[i].n});
            check("R5 not-empty", {31'b0, v[0]}, {31'b0, (VECS[i].n != 2'd0)});
            if (VECS[i].n >= 2'd1) begin
                reg_read(A_CAPTURE, v, vw);
                check("R2 R3 first entry", v, {24'h0, VECS[i].b0});
            end
            if (VECS[i].n == 2'd2) begin
                reg_read(A_CAPTURE, v, vw);
                check("R3 second entry", v, {24'h0, VECS[i].b1});
            end
            reg_read(A_STATUS, v, vw);
            check("R5 drained", v, 32'h0);
        end

        // R3: consecutive byte writes keep arrival order (81h before 80h)
        host_write(16'h0081, 2'b01, 16'h00AB, 1'b0);
        host_write(16'h0080, 2'b01, 16'h00CD, 1'b0);
        reg_read(A_CAPTURE, v, vw); check("R3 arrival order 1", v, 32'h0000_00AB);
        reg_read(A_CAPTURE, v, vw); check("R3 arrival order 2", v, 32'h0000_00CD);

        // R2 / R8: time stamps and wrap (narrow copy wraps at 16)
        do_reset();
        ticks(5);
        host_write(16'h0080, 2'b01, 16'h00A1, 1'b0);
        reg_read(A_CAPTURE, v, vw);
        check("R2 stamp field", v, 32'h0000_05A1);
        check("R8 narrow stamp", vw, 32'h0000_05A1);
        ticks(12);
        host_write(16'h0080, 2'b01, 16'h00B2, 1'b0);
        reg_read(A_CAPTURE, v, vw);
        check("R8 stamp advance", v, 32'h0000_11B2);
        check("R8 stamp wrap", vw, 32'h0000_01B2);

        // Interrupt: R9 R10
        do_reset();
        reg_write(A_CONTROL, 32'h0000_0102);
        host_write(16'h0080, 2'b11, 16'h0201, 1'b0);
        @(negedge clk);
        check("R9 fill equal to level no irq", {31'b0, irq}, 32'h0);
        host_write(16'h0080, 2'b01, 16'h0003, 1'b0);
        reg_read(A_INTSRC, v, vw);
        check("R9 pending above level", v, 32'h1);
        check("R10 irq raised", {31'b0, irq}, 32'h1);
        reg_write(A_INTSRC, 32'h1);
        check("R9 clear takes effect", {31'b0, irq}, 32'h0);
        @(negedge clk);
        check("R9 re-assert while above", {31'b0, irq}, 32'h1);
        reg_write(A_CONTROL, 32'h0000_0002);
        check("R10 disabled irq", {31'b0, irq}, 32'h0);
        reg_read(A_INTSRC, v, vw);
        check("R10 pending kept while disabled", v, 32'h1);
        reg_write(A_CONTROL, 32'h0000_0102);
        reg_read(A_CAPTURE, v, vw);
        check("R6 pop head", v, 32'h0000_0001);
        reg_write(A_INTSRC, 32'h1);
        @(negedge clk);
        @(negedge clk);
        check("R9 stays clear at level", {31'b0, irq}, 32'h0);

        // Full queue, overrun, simultaneous pop and push: R7 R11
        do_reset();
        for (int k = 0; k < 8; k++) begin
            host_write(16'h0080, 2'b11, {8'(8'h11 + 2*k), 8'(8'h10 + 2*k)}, 1'b0);
        end
        reg_read(A_STATUS, v, vw); check("R7 full no overrun", v, 32'h0000_1001);
        host_write(16'h0080, 2'b01, 16'h00EE, 1'b0);
        reg_read(A_STATUS, v, vw); check("R7 drop sets overrun", v, 32'h0000_1003);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = A_CAPTURE;
        host_wr = 1'b1; host_addr = 16'h0080; host_be = 2'b01; host_data = 16'h005A;
        #1;
        check("R11 head on same-cycle pop", reg_rdata, 32'h0000_0010);
        @(negedge clk);
        reg_rd = 1'b0; host_wr = 1'b0;
        reg_read(A_STATUS, v, vw); check("R11 fill stays full", v, 32'h0000_1003);
        reg_write(A_STATUS, 32'h2);
        reg_read(A_STATUS, v, vw); check("R7 overrun cleared", v, 32'h0000_1001);
        for (int k = 1; k < 16; k++) begin
            reg_read(A_CAPTURE, v, vw);
            check("R7 drain order", v, {24'h0, 8'(8'h10 + k)});
        end
        reg_read(A_CAPTURE, v, vw); check("R11 pushed byte last", v, 32'h0000_005A);
        reg_read(A_STATUS, v, vw);  check("R5 empty after drain", v, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule